// File: doc/BRIEF.md
# UART Channel Mode Data Router

This block sits between a UART's serial receiver, the host-visible data register and the two byte FIFOs of the channel. It decides, cycle by cycle, which FIFO each arriving byte goes into. A 2-bit channel mode selects one of four routes. Normal operation sends serial bytes to the receive FIFO and host writes to the transmit FIFO. Automatic echo copies each serial byte into both FIFOs. Local loopback feeds host writes back into the receive FIFO. Remote loopback sends serial bytes straight back out through the transmit FIFO.

The block owns the channel control register. That register holds an enable bit and a disable bit for each direction, plus self-clearing flush bits for each FIFO. The block also turns a received break into a zero byte on the receive side. It pops the receive FIFO on host reads, and it signals an overflow when a push meets a full FIFO. A combinational receive-ready output tells the serial front end whether the current mode has room in every FIFO it would write to.

The FIFO storage and the serializer lie outside the block. The FIFOs report their fill levels and the receive head byte, and they act on the push, pop and flush strobes.

Top module: `uart_chm_router`

## Requirements
- R1: After reset the control register reads 0x128 (both directions disabled). Every push, pop, flush and overflow strobe is low, and the host read data is 0.
- R2: In mode 0 (normal), a serial byte is pushed to the RX FIFO and a host data write is pushed to the TX FIFO. Every strobe and its data appear at the outputs one clock after the input strobe.
- R3: In mode 1 (echo), a serial byte is pushed to both the RX FIFO and the TX FIFO, and host data writes are dropped.
- R4: In mode 2 (local loopback), a host data write is pushed to the RX FIFO, and serial bytes are ignored.
- R5: In mode 3 (remote loopback), a serial byte is pushed to the TX FIFO only, and host data writes are dropped.
- R6: A direction is active only when its enable bit is set and its disable bit is clear. RX uses enable bit 2 and disable bit 3; TX uses enable bit 4 and disable bit 5. An inactive direction gets no push, no overflow and no pop.
- R7: Writing control bit 0 pulses rx_flush for one cycle, and writing bit 1 pulses tx_flush for one cycle. Both bits always read back as 0. Bits 2 to 8 are stored as written.
- R8: A received break pushes one 0x00 byte to the RX FIFO in any mode while RX is active. It takes precedence over a serial byte or a loopback host write in the same cycle, and the RX copy of that other byte is dropped.
- R9: A host read while RX is active and the RX level is nonzero pops the FIFO and returns the head byte. Otherwise the host read returns 0 and does not pop. Between reads, host_rdata holds its value.
- R10: A push attempt to a FIFO whose level equals DEPTH, in an active direction, is suppressed and pulses ovr_evt. This applies to both RX and TX.
- R11: rx_ready is high exactly when every FIFO the mode writes from the serial path has a level below DEPTH. That is the RX FIFO in modes 0 and 1 and the TX FIFO in modes 1 and 3. In mode 2, rx_ready is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_mode | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loop, 3 remote loop |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control register write data |
| ctrl_rdata | output | 9 | Control register contents |
| rx_byte_vld | input | 1 | Serial receiver byte strobe |
| rx_byte | input | DATA_W | Received byte |
| rx_break | input | 1 | Break condition received |
| host_wr | input | 1 | Host write to the data register |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | Host read of the data register |
| host_rdata | output | DATA_W | Host read data |
| rx_level | input | LVL_W | RX FIFO fill level |
| tx_level | input | LVL_W | TX FIFO fill level |
| rx_head | input | DATA_W | Oldest byte in the RX FIFO |
| rx_push | output | 1 | RX FIFO push strobe |
| rx_push_data | output | DATA_W | RX FIFO push data |
| tx_push | output | 1 | TX FIFO push strobe |
| tx_push_data | output | DATA_W | TX FIFO push data |
| rx_pop | output | 1 | RX FIFO pop strobe |
| rx_flush | output | 1 | RX FIFO empty command |
| tx_flush | output | 1 | TX FIFO empty command |
| ovr_evt | output | 1 | Overflow event pulse |
| rx_ready | output | 1 | Serial path may deliver a byte |

## Verification
The hardest situations to reach are the collisions. A break can arrive in the same cycle as a serial byte while echo mode sends that byte to TX. A full FIFO can coincide with an inactive direction, where the overflow must stay silent. Random stimulus from a fixed seed draws FIFO levels from a set weighted toward 0, DEPTH-1 and DEPTH. It draws control words with every enable/disable combination, and it raises break, serial and host strobes together often. Directed cases then pin down the reset value, the flush pulses, a read of an empty FIFO and the break-wins ordering.

// File: rtl/uart_chm_pkg.sv
package uart_chm_pkg;

    localparam int CTRL_W = 9;

    // control bit positions; the routing logic decodes these
    localparam int B_RX_FLUSH = 0;
    localparam int B_TX_FLUSH = 1;
    localparam int B_RX_EN    = 2;
    localparam int B_RX_DIS   = 3;
    localparam int B_TX_EN    = 4;
    localparam int B_TX_DIS   = 5;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;

    typedef enum logic [1:0] {
        CHM_NORMAL = 2'd0,
        CHM_ECHO   = 2'd1,
        CHM_LOCAL  = 2'd2,
        CHM_REMOTE = 2'd3
    } chm_mode_e;

    // decoded per-mode routes
    typedef struct packed {
        logic ser_to_rx;
        logic ser_to_tx;
        logic host_to_rx;
        logic host_to_tx;
    } route_t;

    function automatic route_t mode_route(input chm_mode_e m);
        route_t r;
        r.ser_to_rx  = (m == CHM_NORMAL) || (m == CHM_ECHO);
        r.ser_to_tx  = (m == CHM_ECHO)   || (m == CHM_REMOTE);
        r.host_to_rx = (m == CHM_LOCAL);
        r.host_to_tx = (m == CHM_NORMAL);
        return r;
    endfunction

endpackage

// File: rtl/uart_chm_ctrl.sv
module uart_chm_ctrl
    import uart_chm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              rx_active,
    output logic              tx_active,
    output logic              rx_flush_q,
    output logic              tx_flush_q
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              rx_flush;
        logic              tx_flush;
    } cst_t;

    cst_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rx_flush = 1'b0;
        st_d.tx_flush = 1'b0;
        if (wr) begin
            st_d.ctrl             = wdata;
            st_d.ctrl[B_RX_FLUSH] = 1'b0;
            st_d.ctrl[B_TX_FLUSH] = 1'b0;
            st_d.rx_flush         = wdata[B_RX_FLUSH];
            st_d.tx_flush         = wdata[B_TX_FLUSH];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl     <= CTRL_RESET;
            st_q.rx_flush <= 1'b0;
            st_q.tx_flush <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q     = st_q.ctrl;
    assign rx_flush_q = st_q.rx_flush;
    assign tx_flush_q = st_q.tx_flush;
    assign rx_active  = st_q.ctrl[B_RX_EN] && !st_q.ctrl[B_RX_DIS];
    assign tx_active  = st_q.ctrl[B_TX_EN] && !st_q.ctrl[B_TX_DIS];

endmodule

// File: rtl/uart_chm_route.sv
module uart_chm_route
    import uart_chm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic [1:0]        mode,
    input  logic              rx_active,
    input  logic              tx_active,
    input  logic              ser_vld,
    input  logic [DATA_W-1:0] ser_byte,
    input  logic              brk,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    output logic              rx_go,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_go,
    output logic [DATA_W-1:0] tx_data,
    output logic              ovr,
    output logic              ser_ready
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    route_t rt;
    logic   rx_full, tx_full;
    logic   rx_req, tx_req;

    always_comb begin
        rt      = mode_route(chm_mode_e'(mode));
        rx_full = (rx_level >= FULL_LVL);
        tx_full = (tx_level >= FULL_LVL);

        // RX source priority: break, then serial byte, then loopback write
        rx_req  = 1'b1;
        rx_data = '0;
        if (brk) begin
            rx_data = '0;
        end else if (ser_vld && rt.ser_to_rx) begin
            rx_data = ser_byte;
        end else if (host_wr && rt.host_to_rx) begin
            rx_data = host_wdata;
        end else begin
            rx_req = 1'b0;
        end

        tx_req  = 1'b1;
        tx_data = '0;
        if (ser_vld && rt.ser_to_tx) begin
            tx_data = ser_byte;
        end else if (host_wr && rt.host_to_tx) begin
            tx_data = host_wdata;
        end else begin
            tx_req = 1'b0;
        end

        rx_go = rx_req && rx_active && !rx_full;
        tx_go = tx_req && tx_active && !tx_full;
        ovr   = (rx_req && rx_active && rx_full) ||
                (tx_req && tx_active && tx_full);

        ser_ready = !(rt.ser_to_rx && rx_full) && !(rt.ser_to_tx && tx_full);
    end

endmodule

// File: rtl/uart_chm_router.sv
module uart_chm_router
    import uart_chm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        chan_mode,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              rx_byte_vld,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_break,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [DATA_W-1:0] rx_head,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_push_data,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_push_data,
    output logic              rx_pop,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic              ovr_evt,
    output logic              rx_ready
);

    typedef struct packed {
        logic              rx_push;
        logic [DATA_W-1:0] rx_data;
        logic              tx_push;
        logic [DATA_W-1:0] tx_data;
        logic              pop;
        logic [DATA_W-1:0] rdata;
        logic              ovr;
    } ost_t;

    logic              rx_active, tx_active;
    logic              rx_go, tx_go, ovr_c;
    logic [DATA_W-1:0] rx_data_c, tx_data_c;

    ost_t st_d, st_q;

    uart_chm_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (ctrl_wr),
        .wdata      (ctrl_wdata),
        .ctrl_q     (ctrl_rdata),
        .rx_active  (rx_active),
        .tx_active  (tx_active),
        .rx_flush_q (rx_flush),
        .tx_flush_q (tx_flush)
    );

    uart_chm_route #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .LVL_W  (LVL_W)
    ) u_route (
        .mode       (chan_mode),
        .rx_active  (rx_active),
        .tx_active  (tx_active),
        .ser_vld    (rx_byte_vld),
        .ser_byte   (rx_byte),
        .brk        (rx_break),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .rx_level   (rx_level),
        .tx_level   (tx_level),
        .rx_go      (rx_go),
        .rx_data    (rx_data_c),
        .tx_go      (tx_go),
        .tx_data    (tx_data_c),
        .ovr        (ovr_c),
        .ser_ready  (rx_ready)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rx_push = rx_go;
        st_d.rx_data = rx_data_c;
        st_d.tx_push = tx_go;
        st_d.tx_data = tx_data_c;
        st_d.ovr     = ovr_c;
        st_d.pop     = 1'b0;
        if (host_rd) begin
            if (rx_active && (rx_level != '0)) begin
                st_d.pop   = 1'b1;
                st_d.rdata = rx_head;
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_push      = st_q.rx_push;
    assign rx_push_data = st_q.rx_data;
    assign tx_push      = st_q.tx_push;
    assign tx_push_data = st_q.tx_data;
    assign rx_pop       = st_q.pop;
    assign host_rdata   = st_q.rdata;
    assign ovr_evt      = st_q.ovr;

endmodule

// File: rtl/uart_chm_chk.sv
module uart_chm_chk #(
    parameter int DEPTH  = 64,
    parameter int LVL_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       chan_mode,
    input logic [8:0]       ctrl_rdata,
    input logic             rx_byte_vld,
    input logic             rx_break,
    input logic             host_wr,
    input logic             host_rd,
    input logic [LVL_W-1:0] rx_level,
    input logic             rx_push,
    input logic             tx_push,
    input logic             rx_pop,
    input logic             rx_ready
);

    // R7
    flush_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[1:0] == 2'b00);

    // R6
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(ctrl_rdata[2] && !ctrl_rdata[3]));

    // R6
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(ctrl_rdata[4] && !ctrl_rdata[5]));

    // R10
    rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ($past(rx_level) < LVL_W'(DEPTH)));

    // R9
    pop_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> $past(host_rd && rx_level != '0));

    // R3
    echo_drop_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'd1 && host_wr && !rx_byte_vld && !rx_break)
        |=> (!tx_push && !rx_push));

    // R11
    local_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'd2) |-> rx_ready);

endmodule

bind uart_chm_router uart_chm_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_mode   (chan_mode),
    .ctrl_rdata  (ctrl_rdata),
    .rx_byte_vld (rx_byte_vld),
    .rx_break    (rx_break),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .rx_level    (rx_level),
    .rx_push     (rx_push),
    .tx_push     (tx_push),
    .rx_pop      (rx_pop),
    .rx_ready    (rx_ready)
);

// File: tb/sim_uart_chm_router.sv
module sim_uart_chm_router;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int LVL_W      = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       chan_mode;
    logic             ctrl_wr;
    logic [8:0]       ctrl_wdata;
    logic [8:0]       ctrl_rdata;
    logic             rx_byte_vld;
    logic [7:0]       rx_byte;
    logic             rx_break;
    logic             host_wr;
    logic [7:0]       host_wdata;
    logic             host_rd;
    logic [7:0]       host_rdata;
    logic [LVL_W-1:0] rx_level;
    logic [LVL_W-1:0] tx_level;
    logic [7:0]       rx_head;
    logic             rx_push, tx_push, rx_pop, rx_flush, tx_flush, ovr_evt, rx_ready;
    logic [7:0]       rx_push_data, tx_push_data;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [8:0] m_ctrl;
    logic [7:0] m_rdata;

    // expected values
    logic       e_rxp, e_txp, e_pop, e_ovr, e_rfl, e_tfl, e_rdy;
    logic [7:0] e_rxd, e_txd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_chm_router #(.DATA_W(8), .DEPTH(DEPTH)) u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    // expected outputs from the requirements, for the inputs now driven
    task automatic predict();
        logic rxa, txa, rsrc, tsrc, ser_rx, ser_tx;
        logic [7:0] rd, td;
        rxa    = m_ctrl[2] && !m_ctrl[3];
        txa    = m_ctrl[4] && !m_ctrl[5];
        ser_rx = (chan_mode == 2'd0) || (chan_mode == 2'd1);
        ser_tx = (chan_mode == 2'd1) || (chan_mode == 2'd3);
        rsrc = 1'b0; rd = 8'h00;
        if (rx_break) begin rsrc = 1'b1; rd = 8'h00; end
        else if (rx_byte_vld && ser_rx) begin rsrc = 1'b1; rd = rx_byte; end
        else if (host_wr && chan_mode == 2'd2) begin rsrc = 1'b1; rd = host_wdata; end
        tsrc = 1'b0; td = 8'h00;
        if (rx_byte_vld && ser_tx) begin tsrc = 1'b1; td = rx_byte; end
        else if (host_wr && chan_mode == 2'd0) begin tsrc = 1'b1; td = host_wdata; end
        e_rxp = rsrc && rxa && (rx_level < DEPTH);
        e_txp = tsrc && txa && (tx_level < DEPTH);
        e_ovr = (rsrc && rxa && rx_level == DEPTH) || (tsrc && txa && tx_level == DEPTH);
        e_rxd = rd;
        e_txd = td;
        e_pop = host_rd && rxa && (rx_level != 0);
        e_rfl = ctrl_wr && ctrl_wdata[0];
        e_tfl = ctrl_wr && ctrl_wdata[1];
        e_rdy = !(ser_rx && rx_level == DEPTH) && !(ser_tx && tx_level == DEPTH);
    endtask

    // one cycle: inputs already driven at the falling edge
    task automatic step();
        string mt;
        mt = mode_tag(chan_mode);
        #1;
        predict();
        chk("R11 rx_ready", rx_ready, e_rdy);
        @(posedge clk);
        #1;
        if (host_rd) m_rdata = e_pop ? rx_head : 8'h00;
        if (ctrl_wr) m_ctrl = ctrl_wdata & 9'h1FC;
        chk({mt, " rx_push"}, rx_push, e_rxp);
        if (e_rxp) chk({mt, " rx_push_data"}, rx_push_data, e_rxd);
        chk({mt, " tx_push"}, tx_push, e_txp);
        if (e_txp) chk({mt, " tx_push_data"}, tx_push_data, e_txd);
        chk("R10 ovr_evt", ovr_evt, e_ovr);
        chk("R9 rx_pop", rx_pop, e_pop);
        chk("R9 host_rdata", host_rdata, m_rdata);
        chk("R7 rx_flush", rx_flush, e_rfl);
        chk("R7 tx_flush", tx_flush, e_tfl);
        chk("R7 ctrl_rdata", ctrl_rdata, m_ctrl);
        @(negedge clk);
        ctrl_wr = 0; rx_byte_vld = 0; rx_break = 0; host_wr = 0; host_rd = 0;
    endtask

    task automatic set_ctrl(input logic [8:0] v);
        ctrl_wr = 1; ctrl_wdata = v;
        step();
    endtask

    function automatic logic [LVL_W-1:0] pick_lvl();
        case ($urandom_range(0, 5))
            0:       return '0;
            1:       return LVL_W'(DEPTH - 1);
            2, 3:    return LVL_W'(DEPTH);
            default: return LVL_W'($urandom_range(1, DEPTH - 2));
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 0; chan_mode = 0; ctrl_wr = 0; ctrl_wdata = 0;
        rx_byte_vld = 0; rx_byte = 0; rx_break = 0;
        host_wr = 0; host_wdata = 0; host_rd = 0;
        rx_level = 0; tx_level = 0; rx_head = 0;
        m_ctrl = 9'h128; m_rdata = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ctrl_rdata", ctrl_rdata, 9'h128);
        chk("R1 strobes", {rx_push, tx_push, rx_pop, rx_flush, tx_flush, ovr_evt}, 6'b0);
        chk("R1 host_rdata", host_rdata, 8'h00);
        rst_n = 1;
        @(negedge clk);

        // R6: disabled at reset, nothing is pushed or popped even when full
        rx_level = LVL_W'(DEPTH); rx_byte_vld = 1; rx_byte = 8'hA5; host_wr = 1; host_rd = 1;
        step();
        chk("R6 no ovr while disabled", ovr_evt, 1'b0);

        // R7: flush bits pulse and read back zero; enable both directions
        set_ctrl(9'h017);
        chk("R7 flush bits clear", ctrl_rdata[1:0], 2'b00);
        step();
        chk("R7 flush one cycle", {rx_flush, tx_flush}, 2'b00);

        // R2: normal mode routes
        chan_mode = 0; rx_level = 3; tx_level = 0;
        rx_byte_vld = 1; rx_byte = 8'h3C; host_wr = 1; host_wdata = 8'hC3;
        step();

        // R8: break wins over same-cycle serial byte in echo mode
        chan_mode = 1; rx_break = 1; rx_byte_vld = 1; rx_byte = 8'h77;
        step();

        // R9: empty read returns zero, no pop
        rx_level = 0; rx_head = 8'h99; host_rd = 1;
        step();
        chk("R9 empty read zero", host_rdata, 8'h00);

        // R10: TX overflow in remote loopback
        chan_mode = 3; tx_level = LVL_W'(DEPTH); rx_byte_vld = 1; rx_byte = 8'h11;
        step();
        chk("R10 tx overflow seen", ovr_evt, 1'b1);

        // R4: local loopback writes host byte into RX
        chan_mode = 2; rx_level = 5; host_wr = 1; host_wdata = 8'h5A; rx_byte_vld = 1;
        step();

        // R6: disable RX only, echo still goes to TX
        set_ctrl(9'h01C);
        chan_mode = 1; rx_level = 0; tx_level = 0; rx_byte_vld = 1; rx_byte = 8'h42; host_rd = 1;
        step();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            chan_mode   = 2'($urandom_range(0, 3));
            rx_level    = pick_lvl();
            tx_level    = pick_lvl();
            rx_head     = 8'($urandom);
            rx_byte     = 8'($urandom);
            host_wdata  = 8'($urandom);
            rx_byte_vld = ($urandom_range(0, 1) == 1);
            rx_break    = ($urandom_range(0, 7) == 0);
            host_wr     = ($urandom_range(0, 2) == 0);
            host_rd     = ($urandom_range(0, 2) == 0);
            ctrl_wr     = ($urandom_range(0, 9) == 0);
            ctrl_wdata  = 9'($urandom);
            if (ctrl_wr && $urandom_range(0, 1) == 1) ctrl_wdata[5:2] = 4'b0101;
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule